// File: doc/BRIEF.md
# Indexed Predicate Bank with Issue Gating

This block replaces shared condition-code flags with a bank of one-bit predicates. A compare unit writes its true/false outcome into a predicate chosen by index. It can also write the complement of that outcome into a second index in the same cycle. On the issue side, each instruction names one predicate through a 6-bit field. The block answers, one clock later, whether that instruction may commit its effects or must be squashed.

Predicate 0 is hardwired true, so instructions that should always run can name it. A predicate written in the same cycle that an instruction reads it is forwarded to that instruction. No instruction ever sees a stale value. A synchronous reset clears every writable predicate to false.

Top module: `pred_gate_file`

## Requirements
- R1: The bank holds 64 one-bit predicates, addressed by a 6-bit index from 0 to 63. Each of indices 1 to 63 can be written and read on its own, without affecting the others.
- R2: When `iss_valid` is 1, the outputs respond one clock later. `exec_ok` is 1 and `squash` is 0 if the selected predicate is 1; `exec_ok` is 0 and `squash` is 1 if it is 0.
- R3: When `iss_valid` is 0, both `exec_ok` and `squash` are 0 in the next cycle, whatever the index.
- R4: When `cmp_wr_en` is 1, `cmp_val` is stored into predicate `cmp_idx` at the clock edge. The stored value is seen by instructions issued in later cycles.
- R5: When `cmp_wr2_en` is 1, the complement of `cmp_val` is stored into predicate `cmp_idx2` in the same cycle.
- R6: If both writes are enabled and `cmp_idx` equals `cmp_idx2`, the primary value `cmp_val` is stored.
- R7: Predicate 0 always reads 1. Writes to index 0, through either destination, are ignored.
- R8: If an issue reads an index that is written in the same cycle, the gate decision uses the newly written value. The primary write has priority over the second destination.
- R9: A synchronous active-high `rst` clears predicates 1 to 63 to 0 and drives both outputs to 0.
- R10: `exec_ok` and `squash` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_wr_en | input | 1 | Primary compare write enable |
| cmp_idx | input | 6 | Primary destination predicate index |
| cmp_val | input | 1 | Compare outcome |
| cmp_wr2_en | input | 1 | Complement destination write enable |
| cmp_idx2 | input | 6 | Complement destination predicate index |
| iss_valid | input | 1 | Issue strobe |
| iss_idx | input | 6 | Predicate field of the issuing instruction |
| exec_ok | output | 1 | Registered: instruction may commit |
| squash | output | 1 | Registered: instruction must be suppressed |

## Verification
The hardest case to create is a collision in a single cycle. An issue reads an index while the primary destination, the complement destination, or both target that same index. Here the bank value, the forwarded primary value and the forwarded complement all disagree. The directed tasks first load the target predicate with the opposite of the value to be written. They then drive the write and the issue on the same falling edge, so only a correct forward with primary priority gives the expected gate result.

// File: rtl/pred_pkg.sv
package pred_pkg;
  localparam int unsigned PRED_N  = 64;
  localparam int unsigned PRED_IW = $clog2(PRED_N);

  typedef enum logic [1:0] {
    GATE_IDLE   = 2'd0,
    GATE_EXEC   = 2'd1,
    GATE_SQUASH = 2'd2
  } gate_e;
endpackage

// File: rtl/pred_bank.sv
module pred_bank #(
  parameter int unsigned NUM_PRED = 64,
  localparam int unsigned IDX_W = $clog2(NUM_PRED)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wa_en,
  input  logic [IDX_W-1:0] wa_idx,
  input  logic             wa_val,
  input  logic             wb_en,
  input  logic [IDX_W-1:0] wb_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_bit
);
  logic [NUM_PRED-1:0] bits;

  for (genvar i = 0; i < NUM_PRED; i++) begin : g_cell
    if (i == 0) begin : g_true
      assign bits[i] = 1'b1;
    end else begin : g_flop
      logic q;
      always_ff @(posedge clk) begin
        if (rst)
          q <= 1'b0;
        else if (wa_en && wa_idx == IDX_W'(i))
          q <= wa_val;
        else if (wb_en && wb_idx == IDX_W'(i))
          q <= ~wa_val;
      end
      assign bits[i] = q;
    end
  end

  assign rd_bit = bits[rd_idx];
endmodule

// File: rtl/pred_fwd.sv
module pred_fwd #(
  parameter int unsigned IDX_W = 6
) (
  input  logic             wa_en,
  input  logic [IDX_W-1:0] wa_idx,
  input  logic             wa_val,
  input  logic             wb_en,
  input  logic [IDX_W-1:0] wb_idx,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             bank_bit,
  output logic             eff_bit
);
  logic zero_sel;
  assign zero_sel = (rd_idx == '0);

  always_comb begin
    if (zero_sel)
      eff_bit = 1'b1;
    else if (wa_en && wa_idx == rd_idx)
      eff_bit = wa_val;
    else if (wb_en && wb_idx == rd_idx)
      eff_bit = ~wa_val;
    else
      eff_bit = bank_bit;
  end
endmodule

// File: rtl/pred_gate_ctl.sv
module pred_gate_ctl
  import pred_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic valid,
  input  logic pred_bit,
  output logic exec_ok,
  output logic squash
);
  gate_e state_q, state_d;

  always_comb begin
    if (!valid)
      state_d = GATE_IDLE;
    else if (pred_bit)
      state_d = GATE_EXEC;
    else
      state_d = GATE_SQUASH;
  end

  always_ff @(posedge clk) begin
    if (rst)
      state_q <= GATE_IDLE;
    else
      state_q <= state_d;
  end

  assign exec_ok = (state_q == GATE_EXEC);
  assign squash  = (state_q == GATE_SQUASH);
endmodule

// File: rtl/pred_gate_file.sv
module pred_gate_file #(
  parameter int unsigned NUM_PRED = pred_pkg::PRED_N,
  localparam int unsigned IDX_W = $clog2(NUM_PRED)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_wr_en,
  input  logic [IDX_W-1:0] cmp_idx,
  input  logic             cmp_val,
  input  logic             cmp_wr2_en,
  input  logic [IDX_W-1:0] cmp_idx2,
  input  logic             iss_valid,
  input  logic [IDX_W-1:0] iss_idx,
  output logic             exec_ok,
  output logic             squash
);
  logic bank_bit;
  logic eff_bit;

  pred_bank #(.NUM_PRED(NUM_PRED)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .wa_en  (cmp_wr_en),
    .wa_idx (cmp_idx),
    .wa_val (cmp_val),
    .wb_en  (cmp_wr2_en),
    .wb_idx (cmp_idx2),
    .rd_idx (iss_idx),
    .rd_bit (bank_bit)
  );

  pred_fwd #(.IDX_W(IDX_W)) u_fwd (
    .wa_en    (cmp_wr_en),
    .wa_idx   (cmp_idx),
    .wa_val   (cmp_val),
    .wb_en    (cmp_wr2_en),
    .wb_idx   (cmp_idx2),
    .rd_idx   (iss_idx),
    .bank_bit (bank_bit),
    .eff_bit  (eff_bit)
  );

  pred_gate_ctl u_ctl (
    .clk      (clk),
    .rst      (rst),
    .valid    (iss_valid),
    .pred_bit (eff_bit),
    .exec_ok  (exec_ok),
    .squash   (squash)
  );
endmodule

// File: rtl/pred_gate_chk.sv
module pred_gate_chk #(
  parameter int unsigned IDX_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             cmp_wr_en,
  input logic [IDX_W-1:0] cmp_idx,
  input logic             cmp_val,
  input logic             cmp_wr2_en,
  input logic [IDX_W-1:0] cmp_idx2,
  input logic             iss_valid,
  input logic [IDX_W-1:0] iss_idx,
  input logic             exec_ok,
  input logic             squash
);
  assert_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(exec_ok && squash));

  assert_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !iss_valid |=> (!exec_ok && !squash));

  assert_respond_R2: assert property (@(posedge clk) disable iff (rst)
    iss_valid |=> (exec_ok || squash));

  assert_zero_true_R7: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_idx == '0) |=> exec_ok);

  assert_fwd_primary_R8: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && cmp_wr_en && cmp_idx == iss_idx && iss_idx != '0)
      |=> (exec_ok == $past(cmp_val)));

  assert_fwd_second_R5: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && cmp_wr2_en && cmp_idx2 == iss_idx && iss_idx != '0 &&
     !(cmp_wr_en && cmp_idx == iss_idx))
      |=> (exec_ok == !$past(cmp_val)));
endmodule

bind pred_gate_file pred_gate_chk #(.IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmp_wr_en  (cmp_wr_en),
  .cmp_idx    (cmp_idx),
  .cmp_val    (cmp_val),
  .cmp_wr2_en (cmp_wr2_en),
  .cmp_idx2   (cmp_idx2),
  .iss_valid  (iss_valid),
  .iss_idx    (iss_idx),
  .exec_ok    (exec_ok),
  .squash     (squash)
);

// File: tb/pred_gate_file_tb.sv
`timescale 1ns/1ps
module pred_gate_file_tb;
  localparam int IW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmp_wr_en = 1'b0;
  logic [IW-1:0] cmp_idx = '0;
  logic          cmp_val = 1'b0;
  logic          cmp_wr2_en = 1'b0;
  logic [IW-1:0] cmp_idx2 = '0;
  logic          iss_valid = 1'b0;
  logic [IW-1:0] iss_idx = '0;
  logic          exec_ok;
  logic          squash;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pred_gate_file u_dut (
    .clk(clk), .rst(rst),
    .cmp_wr_en(cmp_wr_en), .cmp_idx(cmp_idx), .cmp_val(cmp_val),
    .cmp_wr2_en(cmp_wr2_en), .cmp_idx2(cmp_idx2),
    .iss_valid(iss_valid), .iss_idx(iss_idx),
    .exec_ok(exec_ok), .squash(squash)
  );

  task automatic check_out(input logic exp_ex, input logic exp_sq, input string tag);
    checks++;
    if (exec_ok !== exp_ex || squash !== exp_sq) begin
      errors++;
      $display("FAIL %s exec_ok/squash actual=%b%b expected=%b%b",
               tag, exec_ok, squash, exp_ex, exp_sq);
    end
  endtask

  task automatic write_pred(input logic [IW-1:0] a, input logic v,
                            input logic en2, input logic [IW-1:0] b);
    @(negedge clk);
    cmp_wr_en = 1'b1; cmp_idx = a; cmp_val = v;
    cmp_wr2_en = en2; cmp_idx2 = b;
    @(negedge clk);
    cmp_wr_en = 1'b0; cmp_wr2_en = 1'b0;
  endtask

  task automatic probe(input logic [IW-1:0] idx, input logic exp, input string tag);
    @(negedge clk);
    iss_valid = 1'b1; iss_idx = idx;
    @(negedge clk);
    iss_valid = 1'b0;
    check_out(exp, !exp, tag);
  endtask

  task automatic t_reset();
    check_out(1'b0, 1'b0, "R9 outputs after reset");
    probe(6'd1, 1'b0, "R9 pred1 cleared");
    probe(6'd63, 1'b0, "R9 pred63 cleared");
    probe(6'd0, 1'b1, "R7 pred0 true after reset");
  endtask

  task automatic t_basic();
    write_pred(6'd5, 1'b1, 1'b0, 6'd0);
    probe(6'd5, 1'b1, "R4 R2 write 1 then execute");
    write_pred(6'd5, 1'b0, 1'b0, 6'd0);
    probe(6'd5, 1'b0, "R4 R2 write 0 then squash");
  endtask

  task automatic t_no_valid();
    write_pred(6'd7, 1'b1, 1'b0, 6'd0);
    @(negedge clk);
    iss_valid = 1'b0; iss_idx = 6'd7;
    @(negedge clk);
    check_out(1'b0, 1'b0, "R3 no strobe true pred");
    iss_idx = 6'd8;
    @(negedge clk);
    check_out(1'b0, 1'b0, "R3 no strobe false pred");
  endtask

  task automatic t_dual();
    write_pred(6'd10, 1'b1, 1'b1, 6'd11);
    probe(6'd10, 1'b1, "R5 primary gets value");
    probe(6'd11, 1'b0, "R5 second gets complement");
    write_pred(6'd10, 1'b0, 1'b1, 6'd11);
    probe(6'd10, 1'b0, "R5 primary gets 0");
    probe(6'd11, 1'b1, "R5 second gets 1");
  endtask

  task automatic t_collide();
    write_pred(6'd20, 1'b1, 1'b1, 6'd20);
    probe(6'd20, 1'b1, "R6 same index primary 1 wins");
    write_pred(6'd20, 1'b0, 1'b1, 6'd20);
    probe(6'd20, 1'b0, "R6 same index primary 0 wins");
  endtask

  task automatic t_zero();
    write_pred(6'd0, 1'b0, 1'b1, 6'd0);
    probe(6'd0, 1'b1, "R7 write to 0 ignored");
    write_pred(6'd3, 1'b0, 1'b1, 6'd0);
    probe(6'd0, 1'b1, "R7 complement write to 0 ignored");
    probe(6'd3, 1'b0, "R7 neighbour written normally");
  endtask

  task automatic t_fwd();
    write_pred(6'd30, 1'b0, 1'b0, 6'd0);
    @(negedge clk);
    cmp_wr_en = 1'b1; cmp_idx = 6'd30; cmp_val = 1'b1;
    iss_valid = 1'b1; iss_idx = 6'd30;
    @(negedge clk);
    cmp_wr_en = 1'b0; iss_valid = 1'b0;
    check_out(1'b1, 1'b0, "R8 primary forwarded");
    probe(6'd30, 1'b1, "R8 value retained");
    @(negedge clk);
    cmp_wr2_en = 1'b1; cmp_idx2 = 6'd30; cmp_val = 1'b1;
    iss_valid = 1'b1; iss_idx = 6'd30;
    @(negedge clk);
    cmp_wr2_en = 1'b0; iss_valid = 1'b0;
    check_out(1'b0, 1'b1, "R8 R5 complement forwarded");
    @(negedge clk);
    cmp_wr_en = 1'b1; cmp_idx = 6'd30; cmp_val = 1'b1;
    cmp_wr2_en = 1'b1; cmp_idx2 = 6'd30;
    iss_valid = 1'b1; iss_idx = 6'd30;
    @(negedge clk);
    cmp_wr_en = 1'b0; cmp_wr2_en = 1'b0; iss_valid = 1'b0;
    check_out(1'b1, 1'b0, "R8 R6 forward priority");
  endtask

  task automatic t_all();
    for (int i = 1; i < 64; i++)
      write_pred(IW'(i), logic'((i % 3) == 1), 1'b0, 6'd0);
    for (int i = 0; i < 64; i++)
      probe(IW'(i), (i == 0) ? 1'b1 : logic'((i % 3) == 1), $sformatf("R1 index %0d", i));
  endtask

  task automatic t_reset2();
    write_pred(6'd44, 1'b1, 1'b0, 6'd0);
    @(negedge clk);
    iss_valid = 1'b1; iss_idx = 6'd44; rst = 1'b1;
    @(negedge clk);
    iss_valid = 1'b0; rst = 1'b0;
    check_out(1'b0, 1'b0, "R9 outputs held low in reset");
    probe(6'd44, 1'b0, "R9 pred44 cleared");
    probe(6'd0, 1'b1, "R9 R7 pred0 still true");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_no_valid();
    t_dual();
    t_collide();
    t_zero();
    t_fwd();
    t_all();
    t_reset2();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule